// File: doc/BRIEF.md
# Input Virtual-Channel Lifecycle Controller

This block keeps the state of every virtual channel (VC) at one input port of a wormhole router. Each VC goes through four phases. It waits idle for a packet. It then routes, waits for an output VC, and finally streams flits to that output until the tail leaves. A flit-arrival strobe writes into the VC named by its index. A route-result strobe and a VC-grant strobe, each tagged with a VC index, drive the phase changes. A departure strobe removes the front flit of an active VC.

Each VC stores its flits as an occupancy counter plus a small store of head flags, so the block can tell whether the front flit opens a packet. Minimum dwell times in the routing phase and in the allocation phase are parameters. An allocator attached to this block sees a request qualifier per VC. It sees the latched route port and, once a VC is active, the granted output port and output VC. Two one-cycle error pulses report a packet that does not begin with a head flit and a write into a full buffer.

Top module: `ivc_ctrl`

## Requirements
- R1: Each VC reports a 2-bit state on `vc_state[2*v+1:2*v]`, encoded idle=0, routing=1, vc_alloc=2, active=3.
- R2: On the clock edge where an idle VC holds at least one flit, the VC moves to routing. If its front flit has the head flag clear, `err_nohead` is high for exactly the following cycle.
- R3: A routing VC moves to vc_alloc on the first edge where both of these hold: its state time is at least `ROUTE_DLY`, and a route result for it was registered in an earlier cycle of this routing phase. The route port is latched. A route result for a VC that is not in routing is ignored.
- R4: `vca_req[v]` is high exactly when VC v is in vc_alloc and its state time is at least `VCA_DLY`.
- R5: A grant to a VC whose `vca_req` is high makes it active and latches `gnt_oport` and `gnt_ovc` onto `vc_oport` and `vc_ovc`. A grant to a VC without a request has no effect.
- R6: The state time of a VC is 0 in the cycle after any state change. Otherwise it grows by one per cycle and saturates at 2^TIME_W-1.
- R7: An arrival at a VC holding `DEPTH` flits is dropped and leaves the count unchanged. `err_overflow` is high for exactly the following cycle.
- R8: A VC count rises by one on an accepted arrival and falls by one on an accepted departure, and is unchanged when both happen. A departure is accepted only from an active, non-empty VC.
- R9: An accepted departure with `dep_tail` set returns the VC to idle.
- R10: A synchronous active-high reset returns every VC to idle, with state time 0, count 0 and both error flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Flit arrival strobe |
| in_vc | input | VCW | VC index of the arriving flit |
| in_head | input | 1 | Arriving flit opens a packet |
| rt_valid | input | 1 | Route result strobe |
| rt_vc | input | VCW | VC the route result belongs to |
| rt_port | input | OPW | Output port chosen by routing |
| gnt_valid | input | 1 | VC grant strobe |
| gnt_vc | input | VCW | Input VC receiving the grant |
| gnt_oport | input | OPW | Granted output port |
| gnt_ovc | input | VCW | Granted output VC |
| dep_valid | input | 1 | Flit departure strobe |
| dep_vc | input | VCW | VC the flit leaves from |
| dep_tail | input | 1 | Departing flit closes its packet |
| vc_state | output | 2*NUM_VC | Per-VC state |
| vc_time | output | TIME_W*NUM_VC | Per-VC cycles in current state |
| vca_req | output | NUM_VC | Per-VC allocation request qualifier |
| vc_rport | output | OPW*NUM_VC | Latched route port |
| vc_oport | output | OPW*NUM_VC | Granted output port |
| vc_ovc | output | VCW*NUM_VC | Granted output VC |
| vc_count | output | CNTW*NUM_VC | Per-VC flit occupancy |
| err_nohead | output | 1 | Packet started without a head flit |
| err_overflow | output | 1 | Arrival into a full VC |

## Verification
Assertions check several rules on every cycle. A state change always restarts the state time. The routing phase is never left before its dwell expires. Activation always follows a request that was granted. Return to idle follows a tail departure. Counts stay within depth and move by at most one per cycle.

Other behaviour depends on several strobes landing in particular cycles, so only the bench scenarios show it. This covers the exact cycle of each transition, the behaviour of ignored route results and ignored grants, the latching of ports, the error pulses, saturation and mid-run reset. The bench covers these with a cycle-accurate reference model under random strobes, plus directed overflow and ignored-grant cases.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    VS_IDLE   = 2'd0,
    VS_ROUTE  = 2'd1,
    VS_ALLOC  = 2'd2,
    VS_ACTIVE = 2'd3
  } vc_st_t;
endpackage

// File: rtl/ivc_buf.sv
module ivc_buf #(
  parameter int NUM_VC = 4,
  parameter int DEPTH  = 4,
  parameter int VCW    = 2,
  parameter int CNTW   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [VCW-1:0]         wr_vc,
  input  logic                   wr_head,
  input  logic                   rd_en,
  input  logic [VCW-1:0]         rd_vc,
  output logic [NUM_VC*CNTW-1:0] cnt_o,
  output logic [NUM_VC-1:0]      front_head,
  output logic [NUM_VC-1:0]      nonempty,
  output logic [NUM_VC-1:0]      full
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // head-flag store, one slot per buffered flit, no reset (RAM style)
  logic hd_mem [NUM_VC*DEPTH];
  logic [PTRW-1:0] wptr [NUM_VC];
  logic [PTRW-1:0] rptr [NUM_VC];
  logic [CNTW-1:0] cnt  [NUM_VC];
  logic            wr_ok;

  assign wr_ok = wr_en && !full[wr_vc];

  always_ff @(posedge clk) begin
    if (wr_ok)
      hd_mem[int'(wr_vc)*DEPTH + int'(wptr[wr_vc])] <= wr_head;
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic we, re;
    assign we = wr_ok && (wr_vc == VCW'(v));
    assign re = rd_en && (rd_vc == VCW'(v)) && (cnt[v] != '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[v]  <= '0;
        wptr[v] <= '0;
        rptr[v] <= '0;
      end else begin
        if (we)
          wptr[v] <= (wptr[v] == PTRW'(DEPTH-1)) ? '0 : wptr[v] + 1'b1;
        if (re)
          rptr[v] <= (rptr[v] == PTRW'(DEPTH-1)) ? '0 : rptr[v] + 1'b1;
        if (we && !re)
          cnt[v] <= cnt[v] + 1'b1;
        else if (re && !we)
          cnt[v] <= cnt[v] - 1'b1;
      end
    end

    assign cnt_o[v*CNTW +: CNTW] = cnt[v];
    assign full[v]       = (cnt[v] == CNTW'(DEPTH));
    assign nonempty[v]   = (cnt[v] != '0);
    assign front_head[v] = hd_mem[v*DEPTH + int'(rptr[v])];

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
      cnt[v] <= CNTW'(DEPTH));
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
      (cnt[v] == $past(cnt[v])) || (cnt[v] == $past(cnt[v]) + 1'b1) ||
      (cnt[v] + 1'b1 == $past(cnt[v])));
  end
endmodule

// File: rtl/ivc_vc_fsm.sv
module ivc_vc_fsm
  import ivc_pkg::*;
#(
  parameter int TIME_W    = 3,
  parameter int OPW       = 3,
  parameter int VCW       = 2,
  parameter int ROUTE_DLY = 2,
  parameter int VCA_DLY   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nonempty,
  input  logic              front_head,
  input  logic              rt_hit,
  input  logic [OPW-1:0]    rt_port,
  input  logic              gnt_hit,
  input  logic [OPW-1:0]    gnt_oport,
  input  logic [VCW-1:0]    gnt_ovc,
  input  logic              tail_out,
  output vc_st_t            st,
  output logic [TIME_W-1:0] tm,
  output logic              req,
  output logic [OPW-1:0]    rport,
  output logic [OPW-1:0]    oport,
  output logic [VCW-1:0]    ovc,
  output logic              hdr_err
);
  localparam logic [TIME_W-1:0] TMAX = {TIME_W{1'b1}};

  vc_st_t nxt;
  logic   rdone;

  assign req = (st == VS_ALLOC) && (tm >= TIME_W'(VCA_DLY));

  always_comb begin
    nxt     = st;
    hdr_err = 1'b0;
    unique case (st)
      VS_IDLE: if (nonempty) begin
        nxt     = VS_ROUTE;
        hdr_err = !front_head;
      end
      VS_ROUTE:  if (rdone && (tm >= TIME_W'(ROUTE_DLY))) nxt = VS_ALLOC;
      VS_ALLOC:  if (gnt_hit && req) nxt = VS_ACTIVE;
      VS_ACTIVE: if (tail_out) nxt = VS_IDLE;
      default:   nxt = VS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= VS_IDLE;
      tm    <= '0;
      rdone <= 1'b0;
      rport <= '0;
      oport <= '0;
      ovc   <= '0;
    end else begin
      st <= nxt;
      if (nxt != st)     tm <= '0;
      else if (tm != TMAX) tm <= tm + 1'b1;
      if (st == VS_ROUTE && rt_hit) rport <= rt_port;
      if (nxt == VS_ROUTE) rdone <= rdone | ((st == VS_ROUTE) && rt_hit);
      else                 rdone <= 1'b0;
      if (st == VS_ALLOC && nxt == VS_ACTIVE) begin
        oport <= gnt_oport;
        ovc   <= gnt_ovc;
      end
    end
  end

  p_time_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (st != $past(st)) |-> (tm == '0));
  p_route_dwell_r3: assert property (@(posedge clk) disable iff (rst)
    (st == VS_ALLOC && $past(st) == VS_ROUTE) |-> ($past(tm) >= TIME_W'(ROUTE_DLY)));
  p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
    (st == VS_ACTIVE && $past(st) != VS_ACTIVE) |-> ($past(req) && $past(gnt_hit)));
  p_idle_after_tail_r9: assert property (@(posedge clk) disable iff (rst)
    (st == VS_IDLE && $past(st) == VS_ACTIVE) |-> $past(tail_out));
endmodule

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_VC    = 4,
  parameter int DEPTH     = 4,
  parameter int NUM_OUT   = 5,
  parameter int TIME_W    = 3,
  parameter int ROUTE_DLY = 2,
  parameter int VCA_DLY   = 1,
  localparam int VCW      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int OPW      = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int CNTW     = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [VCW-1:0]           in_vc,
  input  logic                     in_head,
  input  logic                     rt_valid,
  input  logic [VCW-1:0]           rt_vc,
  input  logic [OPW-1:0]           rt_port,
  input  logic                     gnt_valid,
  input  logic [VCW-1:0]           gnt_vc,
  input  logic [OPW-1:0]           gnt_oport,
  input  logic [VCW-1:0]           gnt_ovc,
  input  logic                     dep_valid,
  input  logic [VCW-1:0]           dep_vc,
  input  logic                     dep_tail,
  output logic [2*NUM_VC-1:0]      vc_state,
  output logic [TIME_W*NUM_VC-1:0] vc_time,
  output logic [NUM_VC-1:0]        vca_req,
  output logic [OPW*NUM_VC-1:0]    vc_rport,
  output logic [OPW*NUM_VC-1:0]    vc_oport,
  output logic [VCW*NUM_VC-1:0]    vc_ovc,
  output logic [CNTW*NUM_VC-1:0]   vc_count,
  output logic                     err_nohead,
  output logic                     err_overflow
);
  vc_st_t              st_arr [NUM_VC];
  logic [NUM_VC-1:0]   front_head, nonempty, full, hdr_err;
  logic                dep_ok;

  assign dep_ok = dep_valid && (st_arr[dep_vc] == VS_ACTIVE) && nonempty[dep_vc];

  ivc_buf #(.NUM_VC(NUM_VC), .DEPTH(DEPTH), .VCW(VCW), .CNTW(CNTW)) u_buf (
    .clk(clk), .rst(rst),
    .wr_en(in_valid), .wr_vc(in_vc), .wr_head(in_head),
    .rd_en(dep_ok), .rd_vc(dep_vc),
    .cnt_o(vc_count), .front_head(front_head), .nonempty(nonempty), .full(full)
  );

  for (genvar v = 0; v < NUM_VC; v++) begin : g_fsm
    logic [TIME_W-1:0] tm_v;
    logic [OPW-1:0]    rp_v, op_v;
    logic [VCW-1:0]    ov_v;
    logic              req_v;

    ivc_vc_fsm #(.TIME_W(TIME_W), .OPW(OPW), .VCW(VCW),
                 .ROUTE_DLY(ROUTE_DLY), .VCA_DLY(VCA_DLY)) u_fsm (
      .clk(clk), .rst(rst),
      .nonempty(nonempty[v]), .front_head(front_head[v]),
      .rt_hit(rt_valid && (rt_vc == VCW'(v))), .rt_port(rt_port),
      .gnt_hit(gnt_valid && (gnt_vc == VCW'(v))),
      .gnt_oport(gnt_oport), .gnt_ovc(gnt_ovc),
      .tail_out(dep_ok && dep_tail && (dep_vc == VCW'(v))),
      .st(st_arr[v]), .tm(tm_v), .req(req_v),
      .rport(rp_v), .oport(op_v), .ovc(ov_v), .hdr_err(hdr_err[v])
    );

    assign vc_state[2*v +: 2]           = st_arr[v];
    assign vc_time[TIME_W*v +: TIME_W]  = tm_v;
    assign vca_req[v]                   = req_v;
    assign vc_rport[OPW*v +: OPW]       = rp_v;
    assign vc_oport[OPW*v +: OPW]       = op_v;
    assign vc_ovc[VCW*v +: VCW]         = ov_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_nohead   <= 1'b0;
      err_overflow <= 1'b0;
    end else begin
      err_nohead   <= |hdr_err;
      err_overflow <= in_valid && full[in_vc];
    end
  end

  p_ovf_flag_r7: assert property (@(posedge clk) disable iff (rst)
    err_overflow |-> $past(in_valid));
  p_depart_active_r8: assert property (@(posedge clk) disable iff (rst)
    dep_ok |-> (vc_state[2*dep_vc +: 2] == 2'd3));
endmodule

// File: tb/sim_ivc_ctrl.sv
module sim_ivc_ctrl;
  localparam int NV = 4, DP = 4, NO = 5, TW = 3, RD = 2, VD = 1;
  localparam int VCW = 2, OPW = 3, CW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_head = 0, rt_valid = 0, gnt_valid = 0, dep_valid = 0, dep_tail = 0;
  logic [VCW-1:0] in_vc = 0, rt_vc = 0, gnt_vc = 0, gnt_ovc = 0, dep_vc = 0;
  logic [OPW-1:0] rt_port = 0, gnt_oport = 0;
  logic [2*NV-1:0] vc_state;
  logic [TW*NV-1:0] vc_time;
  logic [NV-1:0] vca_req;
  logic [OPW*NV-1:0] vc_rport, vc_oport;
  logic [VCW*NV-1:0] vc_ovc;
  logic [CW*NV-1:0] vc_count;
  logic err_nohead, err_overflow;

  int total = 0, bad = 0;
  bit cmp_on = 0, done = 0;

  always #10 clk = ~clk;

  ivc_ctrl #(.NUM_VC(NV), .DEPTH(DP), .NUM_OUT(NO), .TIME_W(TW),
             .ROUTE_DLY(RD), .VCA_DLY(VD)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vc(in_vc), .in_head(in_head),
    .rt_valid(rt_valid), .rt_vc(rt_vc), .rt_port(rt_port),
    .gnt_valid(gnt_valid), .gnt_vc(gnt_vc), .gnt_oport(gnt_oport), .gnt_ovc(gnt_ovc),
    .dep_valid(dep_valid), .dep_vc(dep_vc), .dep_tail(dep_tail),
    .vc_state(vc_state), .vc_time(vc_time), .vca_req(vca_req), .vc_rport(vc_rport),
    .vc_oport(vc_oport), .vc_ovc(vc_ovc), .vc_count(vc_count),
    .err_nohead(err_nohead), .err_overflow(err_overflow));

  // reference model state, built from the requirements
  int m_st[NV], m_tm[NV], m_rd[NV], m_rp[NV], m_op[NV], m_ov[NV], m_cnt[NV];
  int m_q[NV][DP];
  int m_eh = 0, m_eo = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      for (int v = 0; v < NV; v++) begin
        m_st[v] = 0; m_tm[v] = 0; m_rd[v] = 0; m_rp[v] = 0;
        m_op[v] = 0; m_ov[v] = 0; m_cnt[v] = 0;
      end
      m_eh = 0; m_eo = 0;
    end else begin
      int nst;
      int eh = 0;
      bit dep_ok;
      dep_ok = dep_valid && m_st[dep_vc] == 3 && m_cnt[dep_vc] > 0;
      for (int v = 0; v < NV; v++) begin
        bit rth, gh, req, tout;
        rth  = rt_valid && int'(rt_vc) == v;
        gh   = gnt_valid && int'(gnt_vc) == v;
        req  = m_st[v] == 2 && m_tm[v] >= VD;
        tout = dep_ok && dep_tail && int'(dep_vc) == v;
        nst = m_st[v];
        case (m_st[v])
          0: if (m_cnt[v] > 0) begin nst = 1; if (m_q[v][0] == 0) eh = 1; end // R2
          1: if (m_rd[v] != 0 && m_tm[v] >= RD) nst = 2;                      // R3
          2: if (gh && req) begin nst = 3; m_op[v] = gnt_oport; m_ov[v] = gnt_ovc; end // R5
          default: if (tout) nst = 0;                                          // R9
        endcase
        if (m_st[v] == 1 && rth) m_rp[v] = rt_port;
        m_rd[v] = (nst == 1) ? (m_rd[v] | int'(m_st[v] == 1 && rth)) : 0;
        m_tm[v] = (nst != m_st[v]) ? 0 : ((m_tm[v] < 7) ? m_tm[v] + 1 : 7); // R6
        m_st[v] = nst;
      end
      m_eo = (in_valid && m_cnt[in_vc] == DP) ? 1 : 0;                      // R7
      begin
        bit wr_ok;
        wr_ok = in_valid && m_cnt[in_vc] < DP;
        if (dep_ok) begin                                                    // R8
          for (int k = 0; k < DP - 1; k++) m_q[dep_vc][k] = m_q[dep_vc][k+1];
          m_cnt[dep_vc]--;
        end
        if (wr_ok) begin
          m_q[in_vc][m_cnt[in_vc]] = int'(in_head);
          m_cnt[in_vc]++;
        end
      end
      m_eh = eh;
    end
  endtask

  always @(posedge clk) model_step();

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      for (int v = 0; v < NV; v++) begin
        chk("R1 state", int'(vc_state[2*v +: 2]), m_st[v]);
        chk("R6 time", int'(vc_time[TW*v +: TW]), m_tm[v]);
        chk("R4 request", int'(vca_req[v]), int'(m_st[v] == 2 && m_tm[v] >= VD));
        chk("R8 count", int'(vc_count[CW*v +: CW]), m_cnt[v]);
        if (m_st[v] == 2) chk("R3 route port", int'(vc_rport[OPW*v +: OPW]), m_rp[v]);
        if (m_st[v] == 3) begin
          chk("R5 oport", int'(vc_oport[OPW*v +: OPW]), m_op[v]);
          chk("R5 ovc", int'(vc_ovc[VCW*v +: VCW]), m_ov[v]);
        end
      end
      chk("R2 nohead", int'(err_nohead), m_eh);
      chk("R7 overflow", int'(err_overflow), m_eo);
    end
  end

  task automatic idle_inputs();
    in_valid = 0; rt_valid = 0; gnt_valid = 0; dep_valid = 0; dep_tail = 0;
  endtask

  task automatic check_reset_state();
    for (int v = 0; v < NV; v++) begin
      chk("R10 reset state", int'(vc_state[2*v +: 2]), 0);
      chk("R10 reset time", int'(vc_time[TW*v +: TW]), 0);
      chk("R10 reset count", int'(vc_count[CW*v +: CW]), 0);
    end
    chk("R10 reset flags", int'({err_nohead, err_overflow}), 0);
  endtask

  initial begin
    void'($urandom(32'd7123));
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    check_reset_state();

    // directed: grant to an idle VC has no effect (R5)
    gnt_valid = 1; gnt_vc = 0; gnt_oport = 3; gnt_ovc = 1;
    @(negedge clk); idle_inputs();
    chk("R5 grant ignored", int'(vc_state[1:0]), 0);

    // directed: five arrivals to VC2, the last one overflows (R7)
    for (int k = 0; k < 5; k++) begin
      in_valid = 1; in_vc = 2; in_head = (k == 0);
      @(negedge clk);
    end
    idle_inputs();
    chk("R7 overflow pulse", int'(err_overflow), 1);
    chk("R7 count held", int'(vc_count[CW*2 +: CW]), DP);

    // directed: route results to VC2, dwell, grant, drain to tail (R3 R5 R9)
    rt_valid = 1; rt_vc = 2; rt_port = 4;
    @(negedge clk); idle_inputs();
    repeat (4) @(negedge clk);
    chk("R3 reached alloc", int'(vc_state[5:4]), 2);
    gnt_valid = 1; gnt_vc = 2; gnt_oport = 1; gnt_ovc = 3;
    @(negedge clk); idle_inputs();
    chk("R5 active", int'(vc_state[5:4]), 3);
    repeat (10) @(negedge clk);
    chk("R6 saturated", int'(vc_time[TW*2 +: TW]), 7);
    for (int k = 0; k < 4; k++) begin
      dep_valid = 1; dep_vc = 2; dep_tail = (k == 3);
      @(negedge clk);
    end
    idle_inputs();
    chk("R9 back to idle", int'(vc_state[5:4]), 0);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      in_valid  = ($urandom % 2) == 0;
      in_vc     = VCW'($urandom % NV);
      in_head   = ($urandom % 10) < 8;
      rt_valid  = ($urandom % 5) < 2;
      rt_vc     = VCW'($urandom % NV);
      rt_port   = OPW'($urandom % NO);
      gnt_valid = ($urandom % 5) < 2;
      gnt_vc    = VCW'($urandom % NV);
      gnt_oport = OPW'($urandom % NO);
      gnt_ovc   = VCW'($urandom % NV);
      dep_valid = ($urandom % 2) == 0;
      dep_vc    = VCW'($urandom % NV);
      dep_tail  = ($urandom % 10) < 3;
      if (c == 2000) begin
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        idle_inputs();
        check_reset_state();
      end
      @(negedge clk);
    end
    idle_inputs();
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R10 act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule